// File: doc/BRIEF.md
# Store-and-Forward Packet Stream FIFO

This block is a single-clock, RAM-backed FIFO for a beat stream made of data, valid and last. It buffers whole packets and forwards only complete ones. A packet starts leaving only after its final beat has been written. The input side has no ready signal. Logic upstream must keep the buffer from overflowing, and the block protects itself when that fails. The output side drives data, valid and last, and it obeys a pause request. The pause is loosely coupled: any beat already shown with valid is taken by the receiver, so the pause only holds back the next launch. The head word sits in storage that is read without a clock, so the first beat of a packet goes out in the cycle after the block decides to send it.

Two 16-bit status outputs report the words held and the packets counted. The block recovers from three faults by itself. The first is an input packet longer than the limit. The second is a beat that arrives while the buffer is full. The third is an output packet that either runs out of words or grows past the limit. Each recovery ends the packet cleanly, so packets stay aligned afterwards. An output packet that ends this way carries an error flag on its last beat.

Top module: `pkt_sf_fifo`

## Requirements
- R1: After a synchronous reset, out_valid, in_err and out_err are 0, and word_count and pkt_count are both 0.
- R2: A packet of 1 to 2^LEN_EXP−1 beats leaves with its data unchanged and in order. out_last is set only on its final beat and out_err stays 0. Packets leave in arrival order.
- R3: No beat of a packet appears on the output before the cycle after its last beat has been accepted. The first beat appears one cycle after that, provided the output is not paused.
- R4: If out_pause is high in a cycle, out_valid is low in the following cycle.
- R5: word_count equals the number of words stored. pkt_count rises by one for each input packet closed and falls by one for each output beat sent with out_last. It is unchanged when both happen in the same cycle.
- R6: Beat number 2^LEN_EXP of an input packet is stored as that packet's last beat with its error flag set. It leaves with out_last=1 and out_err=1, and in_err is high for exactly the next cycle. Later input beats are discarded up to and including the next in_last.
- R7: An input beat that arrives while word_count = 2^ADDR_W is discarded, and in_err is high in the next cycle. A discarded beat with in_last still closes the packet in pkt_count.
- R8: If an output packet runs out of stored words before a stored last beat, the block sends one extra beat with out_data=0, out_last=1 and out_err=1.
- R9: If output beat number 2^LEN_EXP of a packet is not a stored last beat, it is sent with out_last=1 and out_err=1. The remaining words then form the next output packet.
- R10: out_err is high only on a beat that has both out_valid and out_last high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| srst | input | 1 | Synchronous reset, active high |
| in_data | input | DATA_W | Input beat data |
| in_valid | input | 1 | Input beat present |
| in_last | input | 1 | Input beat ends its packet |
| out_pause | input | 1 | Hold back the next output beat |
| out_data | output | DATA_W | Output beat data |
| out_valid | output | 1 | Output beat present |
| out_last | output | 1 | Output beat ends its packet |
| word_count | output | 16 | Words held in storage |
| pkt_count | output | 16 | Packets counted and not yet sent |
| in_err | output | 1 | One-cycle flag for a truncated or dropped input beat |
| out_err | output | 1 | Output packet ended by recovery, set with out_last |

## Verification
The bench sends a single packet with long gaps between its beats. A design that launches before the last beat would show out_valid during those gaps. Random traffic mixes legal lengths, over-length packets and random pauses. A block that ignored the pause, miscounted the truncation point, or failed to discard the tail of a long packet would produce beats out of order, wrong flags or leftover words. Two directed fills overflow the buffer while the output is paused. In the first, the overflow cuts off a packet's last beat, and a design without underrun recovery would stall or merge that packet with the next one. In the second, a later packet arrives in time to merge with the short one, and a design without the output length limit would send an over-long packet and leave pkt_count misaligned.

// File: rtl/pkt_sf_pkg.sv
package pkt_sf_pkg;

  // Word count after one cycle with an optional push and an optional pop.
  function automatic int unsigned level_next(int unsigned lvl, logic push, logic pop);
    return lvl + (push ? 32'd1 : 32'd0) - (pop ? 32'd1 : 32'd0);
  endfunction

  // True when the zero-based beat index is the first index past the legal length.
  function automatic logic beat_at_limit(int unsigned beat_idx, int unsigned len_exp);
    return beat_idx == ((32'd1 << len_exp) - 32'd1);
  endfunction

  // Packet counter step: closing and sending in the same cycle cancel out.
  function automatic int unsigned count_step(int unsigned cnt, logic inc, logic dec);
    return cnt + (inc ? 32'd1 : 32'd0) - (dec ? 32'd1 : 32'd0);
  endfunction

endpackage

// File: rtl/pkt_sf_store.sv
module pkt_sf_store #(
  parameter int WORD_W = 66,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              srst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              rd_en,
  output logic [WORD_W-1:0] head_word,
  output logic [ADDR_W:0]   level,
  output logic              empty,
  output logic              full
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int LVL_W = ADDR_W + 1;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [LVL_W-1:0]  lvl_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr_q] <= wr_word;
  end

  always_ff @(posedge clk) begin
    if (srst) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      lvl_q    <= '0;
    end else begin
      if (wr_en) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (rd_en) rd_ptr_q <= rd_ptr_q + 1'b1;
      lvl_q <= LVL_W'(pkt_sf_pkg::level_next(32'(lvl_q), wr_en, rd_en));
    end
  end

  assign head_word = mem[rd_ptr_q];
  assign level     = lvl_q;
  assign empty     = (lvl_q == '0);
  assign full      = (lvl_q == LVL_W'(DEPTH));
endmodule

// File: rtl/pkt_sf_ingress.sv
module pkt_sf_ingress #(
  parameter int DATA_W  = 64,
  parameter int LEN_EXP = 5
) (
  input  logic              clk,
  input  logic              srst,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  input  logic              in_last,
  input  logic              store_full,
  output logic              wr_en,
  output logic [DATA_W+1:0] wr_word,
  output logic              pkt_close,
  output logic              trunc_evt,
  output logic              full_drop_evt,
  output logic              in_err
);
  localparam int CNT_W = LEN_EXP;

  logic [CNT_W-1:0] beat_q;
  logic             discard_q;
  logic             err_q;
  logic             take, eff_last;

  assign take          = in_valid & ~discard_q;
  assign trunc_evt     = take & pkt_sf_pkg::beat_at_limit(32'(beat_q), LEN_EXP);
  assign eff_last      = in_last | trunc_evt;
  assign full_drop_evt = take & store_full;
  assign wr_en         = take & ~store_full;
  assign pkt_close     = take & eff_last;
  // Word layout: {error, last, data}
  assign wr_word       = {trunc_evt, eff_last, in_data};

  always_ff @(posedge clk) begin
    if (srst) begin
      beat_q    <= '0;
      discard_q <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      err_q <= trunc_evt | full_drop_evt;
      if (take) beat_q <= eff_last ? '0 : beat_q + 1'b1;
      if (discard_q && in_valid && in_last) discard_q <= 1'b0;
      else if (trunc_evt && !in_last)       discard_q <= 1'b1;
    end
  end

  assign in_err = err_q;
endmodule

// File: rtl/pkt_sf_egress.sv
module pkt_sf_egress #(
  parameter int DATA_W  = 64,
  parameter int LEN_EXP = 5
) (
  input  logic              clk,
  input  logic              srst,
  input  logic              out_pause,
  input  logic              pkt_avail,
  input  logic              empty,
  input  logic [DATA_W+1:0] head_word,
  output logic              rd_en,
  output logic              pkt_done,
  output logic              underrun_evt,
  output logic              limit_evt,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  output logic              out_last,
  output logic              out_err
);
  localparam int CNT_W = LEN_EXP;

  logic [CNT_W-1:0] beat_q;
  logic             busy_q;
  logic             launch, head_last, head_err, beat_last, beat_err;

  assign head_last    = head_word[DATA_W];
  assign head_err     = head_word[DATA_W+1];
  assign launch       = ~out_pause & (busy_q | pkt_avail);
  assign underrun_evt = launch & empty;
  assign rd_en        = launch & ~empty;
  assign limit_evt    = rd_en & ~head_last &
                        pkt_sf_pkg::beat_at_limit(32'(beat_q), LEN_EXP);
  assign beat_last    = underrun_evt | (rd_en & head_last) | limit_evt;
  assign beat_err     = underrun_evt | (rd_en & head_err) | limit_evt;
  assign pkt_done     = launch & beat_last;

  always_ff @(posedge clk) begin
    if (srst) begin
      beat_q    <= '0;
      busy_q    <= 1'b0;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_err   <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= launch;
      out_last  <= launch & beat_last;
      out_err   <= launch & beat_err;
      if (launch) begin
        out_data <= empty ? '0 : head_word[DATA_W-1:0];
        busy_q   <= ~beat_last;
        beat_q   <= beat_last ? '0 : beat_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pkt_sf_fifo.sv
module pkt_sf_fifo #(
  parameter int DATA_W  = 64,
  parameter int ADDR_W  = 10,
  parameter int LEN_EXP = 5
) (
  input  logic              clk,
  input  logic              srst,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  input  logic              in_last,
  input  logic              out_pause,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  output logic              out_last,
  output logic [15:0]       word_count,
  output logic [15:0]       pkt_count,
  output logic              in_err,
  output logic              out_err
);
  localparam int WORD_W = DATA_W + 2;

  logic              wr_en, rd_en, empty, full;
  logic [WORD_W-1:0] wr_word, head_word;
  logic [ADDR_W:0]   level;
  logic              pkt_close, pkt_done, trunc_evt, full_drop_evt;
  logic              underrun_evt, limit_evt;
  logic [15:0]       pkt_q;

  pkt_sf_ingress #(.DATA_W(DATA_W), .LEN_EXP(LEN_EXP)) u_in (
    .clk(clk), .srst(srst), .in_data(in_data), .in_valid(in_valid),
    .in_last(in_last), .store_full(full), .wr_en(wr_en), .wr_word(wr_word),
    .pkt_close(pkt_close), .trunc_evt(trunc_evt),
    .full_drop_evt(full_drop_evt), .in_err(in_err)
  );

  pkt_sf_store #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .srst(srst), .wr_en(wr_en), .wr_word(wr_word), .rd_en(rd_en),
    .head_word(head_word), .level(level), .empty(empty), .full(full)
  );

  pkt_sf_egress #(.DATA_W(DATA_W), .LEN_EXP(LEN_EXP)) u_out (
    .clk(clk), .srst(srst), .out_pause(out_pause), .pkt_avail(pkt_q != '0),
    .empty(empty), .head_word(head_word), .rd_en(rd_en), .pkt_done(pkt_done),
    .underrun_evt(underrun_evt), .limit_evt(limit_evt), .out_data(out_data),
    .out_valid(out_valid), .out_last(out_last), .out_err(out_err)
  );

  always_ff @(posedge clk) begin
    if (srst) pkt_q <= '0;
    else      pkt_q <= 16'(pkt_sf_pkg::count_step(32'(pkt_q), pkt_close, pkt_done));
  end

  assign pkt_count  = pkt_q;
  assign word_count = 16'(level);
endmodule

// File: rtl/pkt_sf_fifo_chk.sv
module pkt_sf_fifo_chk #(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              srst,
  input logic              out_pause,
  input logic              out_valid,
  input logic              out_last,
  input logic              out_err,
  input logic [DATA_W-1:0] out_data,
  input logic              in_err,
  input logic [15:0]       word_count,
  input logic [15:0]       pkt_count,
  input logic              pkt_close,
  input logic              pkt_done,
  input logic              trunc_evt,
  input logic              full_drop_evt,
  input logic              underrun_evt
);
  localparam int DEPTH = 1 << ADDR_W;

  // R10
  err_with_last_chk: assert property (@(posedge clk) disable iff (srst)
    out_err |-> (out_valid && out_last));

  // R5
  fill_bound_chk: assert property (@(posedge clk) disable iff (srst)
    word_count <= 16'(DEPTH));

  // R5
  fill_step_chk: assert property (@(posedge clk) disable iff (srst)
    (word_count == $past(word_count)) || (word_count == $past(word_count) + 16'd1) ||
    (word_count + 16'd1 == $past(word_count)));

  // R5
  pkt_hold_chk: assert property (@(posedge clk) disable iff (srst)
    (pkt_close && pkt_done) |=> $stable(pkt_count));

  // R4
  pause_chk: assert property (@(posedge clk) disable iff (srst)
    $past(out_pause) |-> !out_valid);

  // R3
  whole_pkt_chk: assert property (@(posedge clk) disable iff (srst)
    out_valid |-> ($past(pkt_count) != 16'd0));

  // R7
  full_drop_chk: assert property (@(posedge clk) disable iff (srst)
    full_drop_evt |-> (word_count == 16'(DEPTH)));

  // R7
  full_flag_chk: assert property (@(posedge clk) disable iff (srst)
    full_drop_evt |=> in_err);

  // R6
  trunc_flag_chk: assert property (@(posedge clk) disable iff (srst)
    trunc_evt |=> in_err);

  // R8
  underrun_chk: assert property (@(posedge clk) disable iff (srst)
    underrun_evt |=> (out_valid && out_last && out_err && out_data == '0));
endmodule

bind pkt_sf_fifo pkt_sf_fifo_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .srst(srst), .out_pause(out_pause), .out_valid(out_valid),
  .out_last(out_last), .out_err(out_err), .out_data(out_data), .in_err(in_err),
  .word_count(word_count), .pkt_count(pkt_count), .pkt_close(pkt_close),
  .pkt_done(pkt_done), .trunc_evt(trunc_evt), .full_drop_evt(full_drop_evt),
  .underrun_evt(underrun_evt)
);

// File: tb/tb_pkt_sf_fifo.sv
module tb_pkt_sf_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int DW    = 16;
  localparam int AW    = 5;
  localparam int LE    = 3;
  localparam int DEPTH = 1 << AW;
  localparam int MAXB  = 1 << LE;
  localparam int W     = DW + 2;

  logic clk = 1'b0, srst = 1'b1;
  logic [DW-1:0] in_data = '0;
  logic in_valid = 1'b0, in_last = 1'b0, out_pause = 1'b0;
  logic [DW-1:0] out_data;
  logic out_valid, out_last, in_err, out_err;
  logic [15:0] word_count, pkt_count;

  pkt_sf_fifo #(.DATA_W(DW), .ADDR_W(AW), .LEN_EXP(LE)) dut (
    .clk(clk), .srst(srst), .in_data(in_data), .in_valid(in_valid),
    .in_last(in_last), .out_pause(out_pause), .out_data(out_data),
    .out_valid(out_valid), .out_last(out_last), .word_count(word_count),
    .pkt_count(pkt_count), .in_err(in_err), .out_err(out_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  int pmode = 0;              // 0 pause low, 1 random, 2 pause high
  logic [DW-1:0] next_val = 16'd1;
  logic [W-1:0] expq[$];
  string tagq[$];
  logic [W-1:0] e;
  string etag;
  logic pause_prev = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push_exp(input logic err, input logic last, input logic [DW-1:0] d,
                          input string tag);
    expq.push_back({err, last, d});
    tagq.push_back(tag);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // Output monitor, sampling at the falling edge
  always @(negedge clk) begin
    if (!srst) begin
      if (out_valid) begin
        check(!pause_prev, "R4", "beat launched after pause", 1, 0);
        if (expq.size() == 0) begin
          check(1'b0, "R2", "unexpected beat", {out_err, out_last, out_data}, 0);
        end else begin
          e = expq.pop_front();
          etag = tagq.pop_front();
          check({out_err, out_last, out_data} == e, etag, "output beat",
                {out_err, out_last, out_data}, e);
        end
      end
      pause_prev = out_pause;
    end
  end

  // Pause driver
  initial begin
    forever begin
      @(posedge clk); #1;
      if (pmode == 1) out_pause = ($urandom_range(0, 3) == 0);
      else            out_pause = (pmode == 2);
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  // Send one packet; with auto_exp the expected output follows R2/R6.
  task automatic send_pkt(input int len, input int gap_max, input bit auto_exp,
                          input int err_idx, input string err_tag);
    for (int i = 0; i < len; i++) begin
      if (auto_exp) begin
        if (len < MAXB) push_exp(1'b0, i == len-1, next_val, "R2");
        else if (i < MAXB) push_exp(i == MAXB-1, i == MAXB-1, next_val, "R6");
      end
      in_valid = 1'b1; in_last = (i == len-1); in_data = next_val;
      next_val = next_val + 16'd1;
      tick();
      in_valid = 1'b0; in_last = 1'b0;
      if (i == err_idx) check(in_err == 1'b1, err_tag, "in_err after beat", in_err, 1);
      if (auto_exp && len >= MAXB) begin
        if (i == MAXB-1) check(in_err == 1'b1, "R6", "in_err on truncation", in_err, 1);
        if (i == MAXB)   check(in_err == 1'b0, "R6", "in_err one cycle only", in_err, 0);
      end
      if (gap_max > 0) repeat ($urandom_range(0, gap_max)) tick();
    end
  endtask

  task automatic drain();
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      if (expq.size() == 0 && word_count == 0 && !out_valid) break;
    end
    repeat (3) tick();
  endtask

  task automatic check_idle(input string tag);
    check(word_count == 0, tag, "word_count idle", word_count, 0);
    check(pkt_count == 0, tag, "pkt_count idle", pkt_count, 0);
    check(expq.size() == 0, tag, "missing beats", expq.size(), 0);
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "WD", "watchdog expired", 0, 1);
    report();
    $finish;
  end

  initial begin
    logic [DW-1:0] b5, b6;
    repeat (4) @(posedge clk);
    #1 srst = 1'b0;
    tick();
    // R1 reset state
    check(out_valid == 0, "R1", "out_valid", out_valid, 0);
    check(word_count == 0, "R1", "word_count", word_count, 0);
    check(pkt_count == 0, "R1", "pkt_count", pkt_count, 0);
    check(in_err == 0 && out_err == 0, "R1", "error flags", {in_err, out_err}, 0);

    // R3: slow packet, nothing leaves before its last beat
    for (int i = 0; i < 3; i++) begin
      push_exp(1'b0, i == 2, next_val, "R3");
      in_valid = 1'b1; in_last = (i == 2); in_data = next_val;
      next_val = next_val + 16'd1;
      tick();
      in_valid = 1'b0; in_last = 1'b0;
      if (i < 2) begin
        for (int g = 0; g < 4; g++) begin
          check(out_valid == 0, "R3", "early beat", out_valid, 0);
          tick();
        end
      end
    end
    check(out_valid == 0, "R3", "launch one cycle after last", out_valid, 0);
    check(pkt_count == 1, "R5", "pkt_count after close", pkt_count, 1);
    tick();
    check(out_valid == 1, "R3", "first beat launched", out_valid, 1);
    drain();
    check_idle("R3");

    // R5: counters while paused
    pmode = 2; repeat (3) tick();
    send_pkt(3, 2, 1'b1, -1, "");
    send_pkt(5, 2, 1'b1, -1, "");
    send_pkt(2, 2, 1'b1, -1, "");
    check(word_count == 10, "R5", "word_count paused", word_count, 10);
    check(pkt_count == 3, "R5", "pkt_count paused", pkt_count, 3);
    check(out_valid == 0, "R4", "held while paused", out_valid, 0);
    pmode = 0;
    drain();
    check_idle("R5");

    // R2/R4/R6: random lengths with random pauses, some over-length
    pmode = 1;
    for (int p = 0; p < 200; p++) begin
      int len;
      while (word_count > 16'(DEPTH - 12)) tick();
      len = ($urandom_range(0, 7) == 0) ? int'($urandom_range(MAXB, MAXB + 3))
                                        : int'($urandom_range(1, MAXB - 1));
      send_pkt(len, 2, 1'b1, -1, "");
      if ($urandom_range(0, 1) == 0) repeat ($urandom_range(0, 4)) tick();
    end
    pmode = 0;
    drain();
    check_idle("R6");

    // R7/R8: overflow cuts the last beat, output runs dry
    pmode = 2; repeat (3) tick();
    for (int p = 0; p < 4; p++) send_pkt(7, 0, 1'b1, -1, "");
    b5 = next_val;
    send_pkt(7, 0, 1'b0, 4, "R7");
    check(word_count == 16'(DEPTH), "R7", "word_count full", word_count, DEPTH);
    check(pkt_count == 5, "R7", "dropped last still counted", pkt_count, 5);
    for (int i = 0; i < 4; i++) push_exp(1'b0, 1'b0, b5 + 16'(i), "R8");
    push_exp(1'b1, 1'b1, '0, "R8");
    pmode = 0;
    drain();
    check_idle("R8");

    // R9: short packet merges with the next one past the length limit
    pmode = 2; repeat (3) tick();
    for (int p = 0; p < 4; p++) send_pkt(7, 0, 1'b1, -1, "");
    b5 = next_val;
    send_pkt(7, 0, 1'b0, -1, "");
    for (int i = 0; i < 4; i++) push_exp(1'b0, 1'b0, b5 + 16'(i), "R9");
    pmode = 0;
    repeat (10) tick();
    b6 = next_val;
    for (int i = 0; i < 3; i++) push_exp(1'b0, 1'b0, b6 + 16'(i), "R9");
    push_exp(1'b1, 1'b1, b6 + 16'd3, "R9");
    for (int i = 4; i < 7; i++) push_exp(1'b0, i == 6, b6 + 16'(i), "R9");
    send_pkt(7, 0, 1'b0, -1, "");
    drain();
    check_idle("R9");
    check(out_err == 0, "R10", "out_err idle", out_err, 0);

    report();
    $finish;
  end
endmodule